// File: doc/BRIEF.md
# Readback Data FIFO with Whole-Packet Admission

This block buffers configuration readback data on its way to a host. Upstream logic delivers data as packets of four 32-bit words, all four presented together on a 128-bit bus during one cycle with a valid strobe. The host drains the buffer one word at a time with a read strobe. The word appears on the read data output one cycle after the strobe.

A packet is never split. It is admitted in full only when the buffer has room for all four words. If there is less room, the whole packet is thrown away and a sticky drop flag is raised. A read of an empty buffer does not stall: it returns zero and changes nothing. The host has no write path into the data window. A write strobe only raises a sticky access-error flag. The block reports its fill level and its free-space count. A single clear input resets both flags.

Top module: `readback_fifo`

## Requirements
- R1: After reset the fill level is 0, the free count equals the depth (default 2048 words), both flags are 0 and read data is 0.
- R2: When a packet is valid and the free count is at least 4, all four words are stored, and the level grows by 4 (by 3 if a word is popped in the same cycle).
- R3: Words leave in arrival order. Within a packet, bits [31:0] leave first, then [63:32], then [95:64], then [127:96].
- R4: When a packet is valid and the free count is below 4, no word of it is stored and the drop flag is 1 from the next cycle.
- R5: A read strobe on a non-empty buffer removes exactly one word, and that word is on the read data output in the following cycle.
- R6: A read strobe on an empty buffer leaves the level at 0 and puts 0 on the read data output in the following cycle.
- R7: A host write strobe leaves the level and the stored words unchanged and sets the access-error flag from the next cycle.
- R8: When a packet arrives in the same cycle as a pop, admission is decided on the level before the pop. At level depth-3 the packet is dropped.
- R9: Both flags stay set until the clear input is high at a clock edge. A new error in that same cycle wins over the clear.
- R10: The free count always equals the depth minus the level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pkt_valid | input | 1 | A four-word packet is presented this cycle |
| pkt_data | input | 128 | Packet words; word 0 in bits [31:0] |
| rd_en | input | 1 | Host read strobe, one word per cycle |
| rd_data | output | 32 | Word popped by the previous read (0 if that read found the buffer empty) |
| wr_en | input | 1 | Host write strobe into the data window (rejected) |
| flag_clr | input | 1 | Clears both sticky flags |
| drop_err | output | 1 | Sticky: a packet was discarded for lack of room |
| acc_err | output | 1 | Sticky: a host write was attempted |
| level | output | 12 | Number of words held |
| free_cnt | output | 12 | Number of free word slots |

## Verification
The hardest case to reach is a packet that arrives together with a pop while the buffer sits just under full. Only there does admission on the pre-pop level differ from admission on the post-pop level. Random traffic keeps the buffer shallow, so a directed phase first pushes 512 packets to fill the buffer completely. It then pops back down to levels 2045 and 2044 and presents a packet with a simultaneous pop at each level. After that phase the buffer is drained completely, so that every stored word is checked against the bench's reference queue.

// File: rtl/rbf_pkg.sv
package rbf_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned PKT_WRDS = 4;
  localparam int unsigned PKT_W    = WORD_W * PKT_WRDS;
endpackage

// File: rtl/rbf_ctrl.sv
module rbf_ctrl #(
  parameter int unsigned DEPTH = 2048,
  localparam int unsigned LVL_W = $clog2(DEPTH + 1),
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned ROW_W = $clog2(DEPTH / rbf_pkg::PKT_WRDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pkt_valid,
  input  logic             rd_en,
  output logic             push_ok,
  output logic             pkt_drop,
  output logic             pop_ok,
  output logic [ROW_W-1:0] wr_row,
  output logic [PTR_W-1:0] rd_ptr,
  output logic [LVL_W-1:0] level,
  output logic [LVL_W-1:0] free_cnt
);
  localparam logic [LVL_W-1:0] DEPTH_L = LVL_W'(DEPTH);
  localparam logic [LVL_W-1:0] PKT_L   = LVL_W'(rbf_pkg::PKT_WRDS);

  logic [LVL_W-1:0] lvl_q, lvl_d;
  logic [ROW_W-1:0] wrow_q, wrow_d;
  logic [PTR_W-1:0] rptr_q, rptr_d;

  assign free_cnt = DEPTH_L - lvl_q;
  // admission judged on occupancy before any same-cycle pop
  assign push_ok  = pkt_valid && (free_cnt >= PKT_L);
  assign pkt_drop = pkt_valid && !push_ok;
  assign pop_ok   = rd_en && (lvl_q != '0);

  always_comb begin
    lvl_d  = lvl_q;
    wrow_d = wrow_q;
    rptr_d = rptr_q;
    if (push_ok) begin
      wrow_d = wrow_q + ROW_W'(1);
    end
    if (pop_ok) begin
      rptr_d = rptr_q + PTR_W'(1);
    end
    case ({push_ok, pop_ok})
      2'b10:   lvl_d = lvl_q + PKT_L;
      2'b11:   lvl_d = lvl_q + PKT_L - LVL_W'(1);
      2'b01:   lvl_d = lvl_q - LVL_W'(1);
      default: lvl_d = lvl_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q  <= '0;
      wrow_q <= '0;
      rptr_q <= '0;
    end else begin
      lvl_q  <= lvl_d;
      wrow_q <= wrow_d;
      rptr_q <= rptr_d;
    end
  end

  assign wr_row = wrow_q;
  assign rd_ptr = rptr_q;
  assign level  = lvl_q;

  // R2
  push_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && free_cnt >= PKT_L && !rd_en) |=> level == $past(level) + PKT_L);
  // R4
  drop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && free_cnt < PKT_L && !rd_en) |=> $stable(level));
  // R10
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level <= DEPTH_L);
  // R6
  empty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (level == '0 && !pkt_valid) |=> level == '0);
endmodule

// File: rtl/rbf_store.sv
module rbf_store #(
  parameter int unsigned DEPTH = 2048,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned ROW_W = $clog2(DEPTH / rbf_pkg::PKT_WRDS),
  localparam int unsigned ROWS  = DEPTH / rbf_pkg::PKT_WRDS
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      push_ok,
  input  logic [ROW_W-1:0]          wr_row,
  input  logic [rbf_pkg::PKT_W-1:0] pkt_data,
  input  logic                      rd_en,
  input  logic                      pop_ok,
  input  logic [PTR_W-1:0]          rd_ptr,
  output logic [rbf_pkg::WORD_W-1:0] rd_data
);
  localparam int unsigned SEL_W = $clog2(rbf_pkg::PKT_WRDS);

  logic [rbf_pkg::PKT_W-1:0]  mem [ROWS];
  logic [rbf_pkg::PKT_W-1:0]  row_sel;
  logic [rbf_pkg::WORD_W-1:0] word_sel;
  logic [rbf_pkg::WORD_W-1:0] rd_q, rd_d;
  logic                       rd_upd;

  // one wide row per packet: a single write keeps the packet atomic
  always_ff @(posedge clk) begin
    if (push_ok) begin
      mem[wr_row] <= pkt_data;
    end
  end

  assign row_sel  = mem[rd_ptr[PTR_W-1:SEL_W]];
  assign word_sel = row_sel[rd_ptr[SEL_W-1:0]*rbf_pkg::WORD_W +: rbf_pkg::WORD_W];

  always_comb begin
    rd_upd = rd_en;
    rd_d   = pop_ok ? word_sel : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else if (rd_upd) begin
      rd_q <= rd_d;
    end
  end

  assign rd_data = rd_q;

  // R6
  empty_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !pop_ok) |=> rd_data == '0);
  // R5
  idle_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));
endmodule

// File: rtl/rbf_flags.sv
module rbf_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic drop_ev,
  input  logic wr_ev,
  input  logic flag_clr,
  output logic drop_err,
  output logic acc_err
);
  logic drop_q, drop_d, acc_q, acc_d;

  always_comb begin
    drop_d = (drop_q && !flag_clr) || drop_ev;
    acc_d  = (acc_q && !flag_clr) || wr_ev;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drop_q <= 1'b0;
      acc_q  <= 1'b0;
    end else begin
      drop_q <= drop_d;
      acc_q  <= acc_d;
    end
  end

  assign drop_err = drop_q;
  assign acc_err  = acc_q;

  // R9
  sticky_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_err && !flag_clr) |=> drop_err);
  // R7
  acc_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ev |=> acc_err);
  // R4
  drop_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop_ev |=> drop_err);
endmodule

// File: rtl/readback_fifo.sv
module readback_fifo #(
  parameter int unsigned DEPTH = 2048,
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        pkt_valid,
  input  logic [rbf_pkg::PKT_W-1:0]   pkt_data,
  input  logic                        rd_en,
  output logic [rbf_pkg::WORD_W-1:0]  rd_data,
  input  logic                        wr_en,
  input  logic                        flag_clr,
  output logic                        drop_err,
  output logic                        acc_err,
  output logic [LVL_W-1:0]            level,
  output logic [LVL_W-1:0]            free_cnt
);
  localparam int unsigned PTR_W = $clog2(DEPTH);
  localparam int unsigned ROW_W = $clog2(DEPTH / rbf_pkg::PKT_WRDS);

  logic             push_ok, pkt_drop, pop_ok;
  logic [ROW_W-1:0] wr_row;
  logic [PTR_W-1:0] rd_ptr;

  rbf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .rd_en(rd_en),
    .push_ok(push_ok), .pkt_drop(pkt_drop), .pop_ok(pop_ok),
    .wr_row(wr_row), .rd_ptr(rd_ptr), .level(level), .free_cnt(free_cnt)
  );

  rbf_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .push_ok(push_ok), .wr_row(wr_row),
    .pkt_data(pkt_data), .rd_en(rd_en), .pop_ok(pop_ok), .rd_ptr(rd_ptr),
    .rd_data(rd_data)
  );

  rbf_flags u_flags (
    .clk(clk), .rst_n(rst_n), .drop_ev(pkt_drop), .wr_ev(wr_en),
    .flag_clr(flag_clr), .drop_err(drop_err), .acc_err(acc_err)
  );

  // R10
  free_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (LVL_W + 1)'(free_cnt) + (LVL_W + 1)'(level) == (LVL_W + 1)'(DEPTH));
  // R7
  write_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !pkt_valid && !rd_en) |=> $stable(level));
endmodule

// File: tb/sim_readback_fifo.sv
module sim_readback_fifo;
  localparam int DEPTH = 2048;
  localparam int LVL_W = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pkt_valid = 1'b0;
  logic [127:0] pkt_data = '0;
  logic rd_en = 1'b0;
  logic wr_en = 1'b0;
  logic flag_clr = 1'b0;
  logic [31:0] rd_data;
  logic drop_err, acc_err;
  logic [LVL_W-1:0] level, free_cnt;

  int n_tests = 0;
  int n_fail = 0;
  logic [31:0] mq[$];
  logic [31:0] m_rd = '0;
  bit m_drop = 0, m_acc = 0;
  int unsigned seq = 1;

  always #5 clk = ~clk;

  readback_fifo #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_data(pkt_data),
    .rd_en(rd_en), .rd_data(rd_data), .wr_en(wr_en), .flag_clr(flag_clr),
    .drop_err(drop_err), .acc_err(acc_err), .level(level), .free_cnt(free_cnt)
  );

  function automatic logic [127:0] mk_pkt(int unsigned s);
    return {s * 32'd4 + 32'd3, s * 32'd4 + 32'd2, s * 32'd4 + 32'd1, s * 32'd4} ^ {4{32'hA5000000}};
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one cycle: called at a negedge, returns at the next negedge
  task automatic step(input bit pv, input bit rd, input bit wr, input bit clr, input string req);
    int cnt;
    bit acc_ok, pop;
    logic [127:0] d;
    d = mk_pkt(seq);
    cnt = mq.size();
    pkt_valid = pv; pkt_data = d; rd_en = rd; wr_en = wr; flag_clr = clr;
    acc_ok = pv && (DEPTH - cnt >= 4);   // R8: pre-pop occupancy
    pop = rd && (cnt > 0);
    if (rd) m_rd = pop ? mq[0] : 32'h0;
    if (pop) void'(mq.pop_front());
    if (acc_ok) begin
      for (int k = 0; k < 4; k++) mq.push_back(d[k*32 +: 32]);
      seq++;
    end
    m_drop = (m_drop && !clr) || (pv && !acc_ok);
    m_acc  = (m_acc && !clr) || wr;
    @(posedge clk);
    @(negedge clk);
    pkt_valid = 0; rd_en = 0; wr_en = 0; flag_clr = 0;
    chk(level == LVL_W'(mq.size()), {req, " level"}, level, mq.size());
    chk(free_cnt == LVL_W'(DEPTH - mq.size()), "R10 free", free_cnt, DEPTH - mq.size());
    if (rd) chk(rd_data == m_rd, {req, " rd_data R3"}, rd_data, m_rd);
    chk(drop_err == m_drop, {req, " drop R9"}, drop_err, m_drop);
    chk(acc_err == m_acc, {req, " acc R9"}, acc_err, m_acc);
  endtask

  initial begin
    #2000000;
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(level == 0, "R1 level", level, 0);
    chk(free_cnt == LVL_W'(DEPTH), "R1 free", free_cnt, DEPTH);
    chk(!drop_err && !acc_err, "R1 flags", {drop_err, acc_err}, 0);
    chk(rd_data == 0, "R1 rd_data", rd_data, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R6 read while empty
    step(0, 1, 0, 0, "R6");
    // R7 write attempt, then read-back to confirm nothing stored
    step(0, 0, 1, 0, "R7");
    step(0, 1, 0, 0, "R7 empty after write");
    step(0, 0, 0, 1, "R9 clear");
    // R2/R3/R5 basic push then drain
    step(1, 0, 0, 0, "R2");
    step(1, 1, 0, 0, "R2 push+pop");
    for (int i = 0; i < 8; i++) step(0, 1, 0, 0, "R5");
    // random traffic
    for (int i = 0; i < 3000; i++) begin
      int unsigned r;
      r = $urandom;
      step(r[2:0] == 0, r[4:3] != 0, r[7:5] == 0, r[10:8] == 0, "R2 R5 random");
    end
    while (mq.size() > 0) step(0, 1, 0, 0, "R3 drain");
    step(0, 0, 0, 1, "R9 clear");
    // fill completely
    for (int i = 0; i < DEPTH / 4; i++) step(1, 0, 0, 0, "R2 fill");
    step(1, 0, 0, 0, "R4 full drop");
    step(0, 0, 0, 0, "R9 sticky hold");
    step(1, 0, 0, 1, "R9 set beats clear");
    step(0, 0, 0, 1, "R9 clear");
    for (int i = 0; i < 3; i++) step(0, 1, 0, 0, "R5 pop");
    step(1, 1, 0, 0, "R8 drop at depth-3");
    step(1, 1, 0, 0, "R8 accept at depth-4");
    step(1, 0, 0, 0, "R4 drop at depth-1");
    step(0, 0, 1, 0, "R7 write when full");
    while (mq.size() > 0) step(0, 1, 0, 0, "R3 final drain");
    step(0, 1, 0, 0, "R6 empty again");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule